// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Software Refill Support

This block translates 32-bit virtual addresses into physical addresses through a small, fully associative table of page mappings. Every slot's virtual page tag is compared against the incoming page number at once. The outcome is registered and appears one clock later as one of three results: a hit with the physical address, a refill request (no slot holds the tag), or a page-fault request (the matching slot is marked invalid). Refill and fault have separate request outputs and distinct exception vectors. This keeps the fast refill path apart from the slow fault path.

The block also holds the registers a short refill handler needs. A faulting-address register records the whole virtual address of the last failed lookup. A context register joins a software-written page-table base (bits 31:20) with the failed virtual page number (bits 19:2), and its bits 1:0 are zero. The handler can therefore use the context value directly as the load address of the missing table entry. The handler writes the new mapping into a staging register. A refill-write command then copies the staged mapping into the slot chosen by a free-running counter that advances every clock.

Pages are 16 KB, so the virtual page number is VA[31:14] and VA[13:0] passes through unchanged. The lookup result is tracked by a four-state machine. `ST_IDLE` means no lookup was presented. `ST_HIT` means a valid match. `ST_MISS` means no tag matched. `ST_FAULT` means the match was invalid. Every clock moves the machine to the state given by the lookup on the inputs at that edge:
- idle→any and any→idle transitions follow the lookup strobe.
- Any state goes to `ST_HIT`, `ST_MISS` or `ST_FAULT` by the compare outcome.
- Reset forces `ST_IDLE`.

Top module: `tlb_refill_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every slot's tag, frame, valid and dirty bits to zero. It also clears the faulting-address and context registers, clears all result and request outputs, and sets rand_idx to 15.
- R2: rand_idx advances by one on every clock edge out of reset, whatever the other inputs do, and wraps from 15 to 0.
- R3: When rfl_we is high at an edge, the staged mapping is written into the slot numbered rand_idx at that edge. A lookup at that same edge sees the old slot contents. The new mapping is visible to lookups from the next edge.
- R4: One cycle after a lookup whose VA[31:14] equals a valid slot's tag, hit is 1 and pa = {frame, VA[13:0]}. pa_dirty carries that slot's dirty bit. If several slots match, the lowest-numbered slot decides the result.
- R5: One cycle after a lookup that matches no slot, refill_req is 1, exc_vector is 0x8000_0000 and bad_va holds the full lookup address.
- R6: One cycle after a lookup whose deciding matching slot has valid = 0, fault_req is 1, exc_vector is 0x8000_0180 and bad_va holds the full lookup address.
- R7: context_reg[31:20] takes pt_base_in one cycle after pt_base_we. context_reg[19:2] takes VA[31:14] of each refill or fault lookup in the same cycle bad_va updates. context_reg[1:0] is always 0.
- R8: At most one of hit, refill_req and fault_req is high. All three are low one cycle after an edge with lk_valid low. bad_va and context_reg[19:2] hold their values on hits and idle cycles.
- R9: stg_we loads stg_vpn, stg_pfn, stg_valid and stg_dirty into the staging register. A refill write uses the staged value held before its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | 32 | Virtual address to translate |
| pt_base_we | input | 1 | Write strobe for the page-table base field |
| pt_base_in | input | 12 | New page-table base (context bits 31:20) |
| stg_we | input | 1 | Load the staging register |
| stg_vpn | input | 18 | Staged virtual page tag |
| stg_pfn | input | 18 | Staged physical frame number |
| stg_valid | input | 1 | Staged valid bit |
| stg_dirty | input | 1 | Staged dirty bit |
| rfl_we | input | 1 | Copy the staged mapping into slot rand_idx |
| hit | output | 1 | Lookup hit a valid slot |
| pa | output | 32 | Translated physical address (meaningful with hit) |
| pa_dirty | output | 1 | Dirty bit of the hit slot |
| refill_req | output | 1 | Refill exception request (no matching slot) |
| fault_req | output | 1 | Page-fault exception request (invalid match) |
| exc_vector | output | 32 | Vector of the pending request, zero otherwise |
| bad_va | output | 32 | Address of the last failed lookup |
| context_reg | output | 32 | Page-table base, failed page number, two zero bits |
| rand_idx | output | 4 | Free-running replacement index |

## Verification
Every result is due one clock edge after its stimulus: the hit, address and request outputs, bad_va, the context fields and the advanced rand_idx. The driver sets inputs on the falling edge and pushes the expected outcome at that moment. The monitor pops and compares it just after the next rising edge. In this way each comparison lines up with the single register stage between inputs and outputs. The bench's reference table applies a refill write only after computing the same-edge lookup. This matches the old-contents rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PAGE_BITS = 14;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = 18;
    localparam int PA_W      = PFN_W + PAGE_BITS;
    localparam int BASE_W    = VA_W - VPN_W - 2;
    localparam logic [VA_W-1:0] REFILL_VEC = 32'h8000_0000;
    localparam logic [VA_W-1:0] FAULT_VEC  = 32'h8000_0180;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic             valid;
        logic             dirty;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_MISS  = 2'd2,
        ST_FAULT = 2'd3
    } lk_state_e;
endpackage

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= LAST;
        else if (idx == LAST)
            idx <= '0;
        else
            idx <= idx + 1'b1;
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             match_any,
    output tlb_entry_t       match_entry
);
    tlb_entry_t         slot_q [ENTRIES];
    logic [ENTRIES-1:0] tag_eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                slot_q[g] <= wr_entry;
        end
        assign tag_eq[g] = (slot_q[g].vpn == lk_vpn);
    end

    // lowest-numbered matching slot decides
    always_comb begin
        match_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tag_eq[i])
                match_entry = slot_q[i];
        end
    end

    assign match_any = |tag_eq;
endmodule

// File: rtl/tlb_refill_unit.sv
module tlb_refill_unit
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic              pt_base_we,
    input  logic [BASE_W-1:0] pt_base_in,
    input  logic              stg_we,
    input  logic [VPN_W-1:0]  stg_vpn,
    input  logic [PFN_W-1:0]  stg_pfn,
    input  logic              stg_valid,
    input  logic              stg_dirty,
    input  logic              rfl_we,
    output logic              hit,
    output logic [PA_W-1:0]   pa,
    output logic              pa_dirty,
    output logic              refill_req,
    output logic              fault_req,
    output logic [VA_W-1:0]   exc_vector,
    output logic [VA_W-1:0]   bad_va,
    output logic [VA_W-1:0]   context_reg,
    output logic [IDX_W-1:0]  rand_idx
);
    tlb_entry_t        stage_q;
    tlb_entry_t        m_entry;
    logic              m_any;
    lk_state_e         st_q, st_d;
    logic [PA_W-1:0]   pa_q;
    logic              dirty_q;
    logic [BASE_W-1:0] base_q;
    logic [VPN_W-1:0]  ctx_vpn_q;
    logic [VA_W-1:0]   bad_q;

    tlb_rand_ctr #(.ENTRIES(ENTRIES)) u_rand (
        .clk (clk),
        .rst (rst),
        .idx (rand_idx)
    );

    tlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (rfl_we),
        .wr_idx      (rand_idx),
        .wr_entry    (stage_q),
        .lk_vpn      (lk_va[VA_W-1:PAGE_BITS]),
        .match_any   (m_any),
        .match_entry (m_entry)
    );

    // next-state selection from the lookup on the inputs
    always_comb begin
        if (!lk_valid)
            st_d = ST_IDLE;
        else if (!m_any)
            st_d = ST_MISS;
        else if (m_entry.valid)
            st_d = ST_HIT;
        else
            st_d = ST_FAULT;
    end

    // state register and the data latched with each transition
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            pa_q      <= '0;
            dirty_q   <= 1'b0;
            stage_q   <= '0;
            base_q    <= '0;
            ctx_vpn_q <= '0;
            bad_q     <= '0;
        end else begin
            st_q    <= st_d;
            pa_q    <= {m_entry.pfn, lk_va[PAGE_BITS-1:0]};
            dirty_q <= m_entry.dirty;
            if (stg_we)
                stage_q <= '{vpn: stg_vpn, pfn: stg_pfn, valid: stg_valid, dirty: stg_dirty};
            if (pt_base_we)
                base_q <= pt_base_in;
            if (st_d == ST_MISS || st_d == ST_FAULT) begin
                bad_q     <= lk_va;
                ctx_vpn_q <= lk_va[VA_W-1:PAGE_BITS];
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        hit        = 1'b0;
        refill_req = 1'b0;
        fault_req  = 1'b0;
        exc_vector = '0;
        pa         = '0;
        pa_dirty   = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_HIT: begin
                hit      = 1'b1;
                pa       = pa_q;
                pa_dirty = dirty_q;
            end
            ST_MISS: begin
                refill_req = 1'b1;
                exc_vector = REFILL_VEC;
            end
            ST_FAULT: begin
                fault_req  = 1'b1;
                exc_vector = FAULT_VEC;
            end
        endcase
    end

    assign bad_va      = bad_q;
    assign context_reg = {base_q, ctx_vpn_q, 2'b00};
endmodule

// File: rtl/tlb_refill_unit_chk.sv
module tlb_refill_unit_chk
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             hit,
    input logic             refill_req,
    input logic             fault_req,
    input logic [VA_W-1:0]  exc_vector,
    input logic [VA_W-1:0]  bad_va,
    input logic [VA_W-1:0]  context_reg,
    input logic [IDX_W-1:0] rand_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit, refill_req, fault_req}));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !(hit || refill_req || fault_req));

    // R5
    refill_vec_chk: assert property (@(posedge clk) disable iff (rst)
        refill_req |-> exc_vector == REFILL_VEC);

    // R6
    fault_vec_chk: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> exc_vector == FAULT_VEC);

    // R7
    ctx_page_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_req || fault_req) |-> context_reg[VA_W-BASE_W-1:2] == bad_va[VA_W-1:PAGE_BITS]);

    // R2
    rand_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rand_idx == (($past(rand_idx) == LAST) ? '0 : $past(rand_idx) + 1'b1));
endmodule

bind tlb_refill_unit tlb_refill_unit_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .hit         (hit),
    .refill_req  (refill_req),
    .fault_req   (fault_req),
    .exc_vector  (exc_vector),
    .bad_va      (bad_va),
    .context_reg (context_reg),
    .rand_idx    (rand_idx)
);

// File: tb/tlb_refill_unit_bench.sv
module tlb_refill_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_va = '0;
    logic        pt_base_we = 1'b0;
    logic [11:0] pt_base_in = '0;
    logic        stg_we = 1'b0;
    logic [17:0] stg_vpn = '0;
    logic [17:0] stg_pfn = '0;
    logic        stg_valid = 1'b0;
    logic        stg_dirty = 1'b0;
    logic        rfl_we = 1'b0;
    logic        hit, pa_dirty, refill_req, fault_req;
    logic [31:0] pa, exc_vector, bad_va, context_reg;
    logic [3:0]  rand_idx;

    tlb_refill_unit u_tlb_refill_unit (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
        .pt_base_we(pt_base_we), .pt_base_in(pt_base_in),
        .stg_we(stg_we), .stg_vpn(stg_vpn), .stg_pfn(stg_pfn),
        .stg_valid(stg_valid), .stg_dirty(stg_dirty), .rfl_we(rfl_we),
        .hit(hit), .pa(pa), .pa_dirty(pa_dirty), .refill_req(refill_req),
        .fault_req(fault_req), .exc_vector(exc_vector), .bad_va(bad_va),
        .context_reg(context_reg), .rand_idx(rand_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          kind;   // 0 idle, 1 hit, 2 refill, 3 fault
        logic [31:0] pa;
        logic        dirty;
        logic [31:0] bad;
        logic [31:0] ctx;
        logic [3:0]  rnd;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;

    // reference model
    logic [17:0] r_vpn [16];
    logic [17:0] r_pfn [16];
    logic        r_v [16];
    logic        r_d [16];
    logic [17:0] r_svpn = '0, r_spfn = '0;
    logic        r_sv = 1'b0, r_sd = 1'b0;
    logic [11:0] r_base = '0;
    logic [17:0] r_cvpn = '0;
    logic [31:0] r_bad = '0;
    logic [3:0]  r_rand;

    always @(posedge clk) r_rand <= rst ? 4'd15 : r_rand + 4'd1;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic cyc(input logic lv, input logic [31:0] va,
                       input logic pw, input logic [11:0] pd,
                       input logic sw, input logic [17:0] sv, input logic [17:0] sp,
                       input logic sval, input logic sd, input logic rw);
        exp_t e;
        int   m;
        @(negedge clk);
        lk_valid = lv; lk_va = va; pt_base_we = pw; pt_base_in = pd;
        stg_we = sw; stg_vpn = sv; stg_pfn = sp; stg_valid = sval; stg_dirty = sd;
        rfl_we = rw;
        m = -1;
        for (int i = 0; i < 16; i++)
            if (m < 0 && r_vpn[i] == va[31:14]) m = i;
        e.pa = '0; e.dirty = 1'b0;
        if (!lv) e.kind = 0;
        else if (m < 0) e.kind = 2;
        else if (r_v[m]) begin
            e.kind = 1; e.pa = {r_pfn[m], va[13:0]}; e.dirty = r_d[m];
        end else e.kind = 3;
        if (rw) begin
            r_vpn[r_rand] = r_svpn; r_pfn[r_rand] = r_spfn;
            r_v[r_rand] = r_sv; r_d[r_rand] = r_sd;
        end
        if (sw) begin r_svpn = sv; r_spfn = sp; r_sv = sval; r_sd = sd; end
        if (pw) r_base = pd;
        if (e.kind >= 2) begin r_bad = va; r_cvpn = va[31:14]; end
        e.bad = r_bad;
        e.ctx = {r_base, r_cvpn, 2'b00};
        e.rnd = r_rand + 4'd1;
        exp_q.push_back(e);
    endtask

    task automatic look(input logic [31:0] va);
        cyc(1'b1, va, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic idle();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic stage(input logic [17:0] v, input logic [17:0] p, input logic vl, input logic d);
        cyc(1'b0, '0, 1'b0, '0, 1'b1, v, p, vl, d, 1'b0);
    endtask

    task automatic refill();
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
    endtask

    // monitor: one expected item per rising edge that was driven
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(hit == (e.kind == 1), "R4 hit", {31'd0, hit}, {31'd0, e.kind == 1});
            chk(refill_req == (e.kind == 2), "R5 refill_req", {31'd0, refill_req}, {31'd0, e.kind == 2});
            chk(fault_req == (e.kind == 3), "R6 fault_req", {31'd0, fault_req}, {31'd0, e.kind == 3});
            if (e.kind == 1) begin
                chk(pa == e.pa, "R4 pa", pa, e.pa);
                chk(pa_dirty == e.dirty, "R4 dirty", {31'd0, pa_dirty}, {31'd0, e.dirty});
            end
            if (e.kind == 2) chk(exc_vector == 32'h8000_0000, "R5 vector", exc_vector, 32'h8000_0000);
            if (e.kind == 3) chk(exc_vector == 32'h8000_0180, "R6 vector", exc_vector, 32'h8000_0180);
            if (e.kind == 0) chk(!(hit | refill_req | fault_req), "R8 idle quiet", {29'd0, hit, refill_req, fault_req}, 32'd0);
            chk(bad_va == e.bad, "R8 bad_va", bad_va, e.bad);
            chk(context_reg == e.ctx, "R7 context", context_reg, e.ctx);
            chk(rand_idx == e.rnd, "R2 rand_idx", {28'd0, rand_idx}, {28'd0, e.rnd});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            r_vpn[i] = '0; r_pfn[i] = '0; r_v[i] = 1'b0; r_d[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rand_idx == 4'd15, "R1 rand reset", {28'd0, rand_idx}, 32'd15);
        chk(!(hit | refill_req | fault_req), "R1 outputs clear", {29'd0, hit, refill_req, fault_req}, 32'd0);
        chk(bad_va == 0 && context_reg == 0, "R1 regs clear", bad_va | context_reg, 32'd0);
        rst = 1'b0;
        // R5: miss on empty table
        look(32'h0001_4123);
        // R6: reset tags are zero but invalid -> fault
        look(32'h0000_2abc);
        // R7: base write, then a miss combines base and page number
        cyc(1'b0, '0, 1'b1, 12'hABC, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        look(32'hFFFF_C001);
        // R9 / R3: stage a valid mapping, refill with same-edge lookup seeing old contents
        stage(18'h00005, 18'h0002A, 1'b1, 1'b0);
        cyc(1'b1, 32'h0001_4010, 1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b1);
        look(32'h0001_7FFF);   // R4: hit next cycle
        // R4: dirty mapping, distinct offsets
        stage(18'h3FFFF, 18'h12345, 1'b1, 1'b1);
        refill();
        look(32'hFFFF_C000);
        look(32'hFFFF_FFFF);
        // R6: invalid mapping written by refill -> fault
        stage(18'h00009, 18'h00777, 1'b0, 1'b0);
        refill();
        look(32'h0002_4444);
        // R8: idle cycles hold bad_va and context; R2 counter keeps running
        repeat (20) idle();
        // R9: staging loaded and refill in the same cycle uses the older staged value
        stage(18'h00100, 18'h00AAA, 1'b1, 1'b0);
        cyc(1'b0, '0, 1'b0, '0, 1'b1, 18'h00200, 18'h00BBB, 1'b1, 1'b1, 1'b1);
        look({18'h00100, 14'h0042});
        refill();
        look({18'h00200, 14'h1000});
        // sweep: fill many slots, then look them all up
        for (int k = 0; k < 24; k++) begin
            stage(18'h01000 + 18'(k), 18'h20000 + 18'(k * 3), 1'b1, k[0]);
            refill();
        end
        for (int k = 0; k < 24; k++) look({18'h01000 + 18'(k), 14'(k * 97)});
        repeat (3) idle();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule